// File: doc/BRIEF.md
# Error-Rate Monitor and Mute Controller

This block watches the parity-check error pulses that a digital audio decoder raises on each received sample and decides when the audio outputs must be silenced. It counts those pulses over a measurement window made of a fixed number of frame strobes. At the close of each window it compares the count with a programmable limit. Muting engages when the count is above the limit. It is released only when the count drops below a quarter of that limit. Between the two thresholds the previous state is kept, so the mute does not chatter around a single threshold.

Two control bits choose the window length (128 or 64 frames, which is 128 ms or 64 ms at one frame per millisecond) and the limit (511 or 255 errors). A software unmute enable keeps the output muted while it is low. Loss of frame alignment mutes at once and restarts the measurement. The count of each completed window is latched on an output for status readout. An error-monitor flag reports whether that window went over the limit. The block leaves reset muted and unmutes only after a full aligned window with an acceptable error rate.

Top module: `errmute_ctrl`

## Requirements
- R1: After reset, mute is 1, err_flag is 0 and win_count is 0.
- R2: A window closes on the FRAMES_LONG-th frame strobe when win_sel=0, or on the FRAMES_SHORT-th when win_sel=1. win_count keeps its old value until that strobe. From the clock edge of the closing strobe onward, win_count holds the number of par_err pulses in the window, including a pulse that arrives in the same cycle as the closing strobe.
- R3: The error count saturates at 2^CNT_W-1 and does not wrap.
- R4: At a window close, a count greater than the limit sets the mute decision. The limit is LIMIT_HIGH when lim_sel=0 and LIMIT_LOW when lim_sel=1. mute becomes 1 from that clock edge.
- R5: At a window close, a count with 4*count < limit clears the mute decision. If sw_unmute=1 and align_ok=1, mute becomes 0 from that edge.
- R6: A count with 4*count >= limit and count <= limit leaves the mute decision unchanged.
- R7: While sw_unmute=0, mute is 1 from the next clock edge. The mute decision is not altered by this, so setting sw_unmute back to 1 restores mute to the decision.
- R8: While align_ok=0, mute is 1 from the next clock edge, the frame and error counters are cleared, and the mute decision is set to muted.
- R9: At each window close, err_flag is loaded with (count > limit). It holds that value until the next close.
- R10: The error count restarts from zero at the start of every window, so no error is carried into the next window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_strb | input | 1 | One-cycle pulse per received frame |
| par_err | input | 1 | One-cycle pulse per sample that failed its parity check |
| align_ok | input | 1 | 1 while frame alignment is held |
| win_sel | input | 1 | Window length: 0 = FRAMES_LONG frames, 1 = FRAMES_SHORT frames |
| lim_sel | input | 1 | Error limit: 0 = LIMIT_HIGH, 1 = LIMIT_LOW |
| sw_unmute | input | 1 | 0 forces mute, 1 lets the error-rate decision drive mute |
| mute | output | 1 | 1 = audio outputs silenced |
| err_flag | output | 1 | 1 = the last completed window exceeded the limit |
| win_count | output | CNT_W | Error count latched from the last completed window |

## Verification
The bench builds the block with windows of 8 and 4 frames, limits of 15 and 7, and a 5-bit counter. This keeps each window to a few dozen cycles. It also makes saturation at 31 reachable with a handful of error pulses. With these values the exact boundary counts can be driven under both limits: 15 and 16 around the upper threshold, 3 and 4 around the lower one, and 1, 2 and 8 for the smaller limit. Loss of alignment in the middle of a window and the software override are exercised between windows.

// File: rtl/errmute_pkg.sv
package errmute_pkg;

  // outcome of comparing a closed window count with the thresholds
  typedef enum logic [1:0] {
    VERDICT_HOLD    = 2'd0,
    VERDICT_MUTE    = 2'd1,
    VERDICT_RELEASE = 2'd2
  } verdict_e;

  function automatic int unsigned max_of(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/errmute_window.sv
module errmute_window #(
  parameter int unsigned FRAMES_LONG  = 128,
  parameter int unsigned FRAMES_SHORT = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic frame_strb,
  input  logic align_ok,
  input  logic win_sel,
  output logic close
);
  import errmute_pkg::*;

  localparam int unsigned FRM_MAX = max_of(FRAMES_LONG, FRAMES_SHORT);
  localparam int unsigned FRM_W   = $clog2(FRM_MAX) + 1;
  localparam logic [FRM_W-1:0] LAST_LONG  = FRM_W'(FRAMES_LONG - 1);
  localparam logic [FRM_W-1:0] LAST_SHORT = FRM_W'(FRAMES_SHORT - 1);

  logic [FRM_W-1:0] frm_cnt;
  logic [FRM_W-1:0] last_idx;

  always_comb begin
    last_idx = win_sel ? LAST_SHORT : LAST_LONG;
    // >= so that a switch to the short window mid-way closes at once
    close    = align_ok && frame_strb && (frm_cnt >= last_idx);
  end

  always_ff @(posedge clk) begin
    if (rst || !align_ok) begin
      frm_cnt <= '0;
    end else if (close) begin
      frm_cnt <= '0;
    end else if (frame_strb) begin
      frm_cnt <= frm_cnt + 1'b1;
    end
  end

  // R2: a closing strobe always restarts the frame count
  p_restart_after_close_r2: assert property (@(posedge clk) disable iff (rst)
    close |=> (frm_cnt == '0));

  // R2: without a strobe the frame position never moves
  p_frames_still_r2: assert property (@(posedge clk) disable iff (rst)
    (!frame_strb && align_ok) |=> $stable(frm_cnt));

endmodule

// File: rtl/errmute_errcnt.sv
module errmute_errcnt #(
  parameter int unsigned CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             par_err,
  input  logic             align_ok,
  input  logic             close,
  output logic [CNT_W-1:0] total,
  output logic [CNT_W-1:0] win_count
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt;

  always_comb begin
    if (par_err && (cnt != CNT_MAX)) total = cnt + 1'b1;
    else                             total = cnt;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt       <= '0;
      win_count <= '0;
    end else begin
      if (!align_ok || close) cnt <= '0;
      else                    cnt <= total;
      if (close) win_count <= total;
    end
  end

  // R3: a full counter stays full until the window ends
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
    (cnt == CNT_MAX && align_ok && !close) |=> (cnt == CNT_MAX));

  // R10: every window starts from an empty count
  p_clear_on_close_r10: assert property (@(posedge clk) disable iff (rst)
    close |=> (cnt == '0));

  // R2: the latched count only changes on a close
  p_latch_only_on_close_r2: assert property (@(posedge clk) disable iff (rst)
    !close |=> $stable(win_count));

endmodule

// File: rtl/errmute_hyst.sv
module errmute_hyst #(
  parameter int unsigned CNT_W      = 10,
  parameter int unsigned LIMIT_HIGH = 511,
  parameter int unsigned LIMIT_LOW  = 255
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             close,
  input  logic [CNT_W-1:0] total,
  input  logic             lim_sel,
  input  logic             sw_unmute,
  input  logic             align_ok,
  output logic             mute,
  output logic             err_flag
);
  import errmute_pkg::*;

  localparam int unsigned CMP_W = CNT_W + 2;
  localparam logic [CMP_W-1:0] LIM_H = CMP_W'(LIMIT_HIGH);
  localparam logic [CMP_W-1:0] LIM_L = CMP_W'(LIMIT_LOW);

  logic [CMP_W-1:0] limit;
  logic [CMP_W-1:0] total_x;
  logic [CMP_W-1:0] total_x4;
  logic             above;
  logic             below;
  verdict_e         verdict;
  logic             dec_mute;
  logic             dec_next;

  always_comb begin
    limit    = lim_sel ? LIM_L : LIM_H;
    total_x  = CMP_W'(total);
    total_x4 = {total, 2'b00};
    above    = total_x > limit;
    below    = total_x4 < limit;
    if (above)      verdict = VERDICT_MUTE;
    else if (below) verdict = VERDICT_RELEASE;
    else            verdict = VERDICT_HOLD;

    dec_next = dec_mute;
    if (!align_ok) begin
      dec_next = 1'b1;
    end else if (close) begin
      case (verdict)
        VERDICT_MUTE:    dec_next = 1'b1;
        VERDICT_RELEASE: dec_next = 1'b0;
        default:         dec_next = dec_mute;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dec_mute <= 1'b1;
      mute     <= 1'b1;
      err_flag <= 1'b0;
    end else begin
      dec_mute <= dec_next;
      mute     <= dec_next | ~sw_unmute | ~align_ok;
      if (close) err_flag <= above;
    end
  end

  // R4: a window over the limit mutes
  p_mute_above_r4: assert property (@(posedge clk) disable iff (rst)
    (close && total_x > limit) |=> mute);

  // R5: a quiet window releases when nothing else forces mute
  p_release_below_r5: assert property (@(posedge clk) disable iff (rst)
    (close && total_x4 < limit && sw_unmute && align_ok) |=> !mute);

  // R6: the decision only moves at a close or on alignment loss
  p_hold_between_r6: assert property (@(posedge clk) disable iff (rst)
    (align_ok && !close) |=> $stable(dec_mute));

  // R7: software override mutes
  p_sw_force_r7: assert property (@(posedge clk) disable iff (rst)
    !sw_unmute |=> mute);

  // R8: alignment loss mutes at once
  p_align_force_r8: assert property (@(posedge clk) disable iff (rst)
    !align_ok |=> (mute && dec_mute));

  // R9: the monitor flag follows only window closes
  p_flag_stable_r9: assert property (@(posedge clk) disable iff (rst)
    !close |=> $stable(err_flag));

endmodule

// File: rtl/errmute_ctrl.sv
module errmute_ctrl #(
  parameter int unsigned FRAMES_LONG  = 128,
  parameter int unsigned FRAMES_SHORT = 64,
  parameter int unsigned LIMIT_HIGH   = 511,
  parameter int unsigned LIMIT_LOW    = 255,
  parameter int unsigned CNT_W        = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             frame_strb,
  input  logic             par_err,
  input  logic             align_ok,
  input  logic             win_sel,
  input  logic             lim_sel,
  input  logic             sw_unmute,
  output logic             mute,
  output logic             err_flag,
  output logic [CNT_W-1:0] win_count
);

  logic             close;
  logic [CNT_W-1:0] total;

  errmute_window #(
    .FRAMES_LONG (FRAMES_LONG),
    .FRAMES_SHORT(FRAMES_SHORT)
  ) u_window (
    .clk       (clk),
    .rst       (rst),
    .frame_strb(frame_strb),
    .align_ok  (align_ok),
    .win_sel   (win_sel),
    .close     (close)
  );

  errmute_errcnt #(
    .CNT_W(CNT_W)
  ) u_errcnt (
    .clk      (clk),
    .rst      (rst),
    .par_err  (par_err),
    .align_ok (align_ok),
    .close    (close),
    .total    (total),
    .win_count(win_count)
  );

  errmute_hyst #(
    .CNT_W     (CNT_W),
    .LIMIT_HIGH(LIMIT_HIGH),
    .LIMIT_LOW (LIMIT_LOW)
  ) u_hyst (
    .clk      (clk),
    .rst      (rst),
    .close    (close),
    .total    (total),
    .lim_sel  (lim_sel),
    .sw_unmute(sw_unmute),
    .align_ok (align_ok),
    .mute     (mute),
    .err_flag (err_flag)
  );

  // R1: the block comes out of reset silenced
  p_reset_muted_r1: assert property (@(posedge clk)
    rst |=> (mute && !err_flag && win_count == '0));

endmodule

// File: tb/errmute_ctrl_test.sv
`timescale 1ns/1ps
module errmute_ctrl_test;

  localparam int FL = 8;
  localparam int FS = 4;
  localparam int LH = 15;
  localparam int LL = 7;
  localparam int CW = 5;
  localparam int SAT = (1 << CW) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic frame_strb = 1'b0;
  logic par_err = 1'b0;
  logic align_ok = 1'b1;
  logic win_sel = 1'b0;
  logic lim_sel = 1'b0;
  logic sw_unmute = 1'b0;
  logic mute;
  logic err_flag;
  logic [CW-1:0] win_count;

  int total_checks = 0;
  int bad_checks = 0;
  bit finished = 1'b0;

  typedef struct {
    logic  m;
    logic  f;
    int    c;
    string tag;
  } exp_t;

  exp_t sb_q[$];

  // model state
  logic model_dec = 1'b1;
  int   model_cnt = 0;

  always #5 clk = ~clk;

  errmute_ctrl #(
    .FRAMES_LONG(FL), .FRAMES_SHORT(FS),
    .LIMIT_HIGH(LH), .LIMIT_LOW(LL), .CNT_W(CW)
  ) uut (
    .clk(clk), .rst(rst), .frame_strb(frame_strb), .par_err(par_err),
    .align_ok(align_ok), .win_sel(win_sel), .lim_sel(lim_sel),
    .sw_unmute(sw_unmute), .mute(mute), .err_flag(err_flag),
    .win_count(win_count)
  );

  task automatic check(input string tag, input int act, input int expv);
    total_checks++;
    if (act != expv) begin
      bad_checks++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  // monitor: compares each window result pushed by the driver
  initial begin
    exp_t e;
    forever begin
      wait (sb_q.size() != 0);
      e = sb_q.pop_front();
      check({e.tag, " mute"}, int'(mute), int'(e.m));
      check({e.tag, " err_flag"}, int'(err_flag), int'(e.f));
      check({e.tag, " win_count"}, int'(win_count), e.c);
    end
  end

  // driver: one full window, expectation pushed once outputs have settled
  task automatic run_window(input int nfr, input int nerr, input bit err_last,
                            input string tag);
    int   tot;
    int   lim;
    logic above;
    exp_t e;
    for (int i = 0; i < nerr; i++) begin
      @(negedge clk); par_err = 1'b1;
      @(negedge clk); par_err = 1'b0;
    end
    for (int f = 0; f < nfr; f++) begin
      @(negedge clk);
      frame_strb = 1'b1;
      par_err = (f == nfr - 1) ? err_last : 1'b0;
      @(negedge clk);
      frame_strb = 1'b0;
      par_err = 1'b0;
      if (f == nfr - 2) check({tag, " R2 count held before close"}, int'(win_count), model_cnt);
    end
    tot = nerr + int'(err_last);
    if (tot > SAT) tot = SAT;
    lim = lim_sel ? LL : LH;
    above = (tot > lim);
    if (above) model_dec = 1'b1;
    else if (4 * tot < lim) model_dec = 1'b0;
    model_cnt = tot;
    e.m = model_dec | ~sw_unmute;
    e.f = above;
    e.c = tot;
    e.tag = tag;
    sb_q.push_back(e);
    @(negedge clk);
  endtask

  initial begin
    #500000;
    if (!finished) begin
      total_checks++;
      bad_checks++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("  test done: total=%0d bad=%0d", total_checks, bad_checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 reset mute", int'(mute), 1);
    check("R1 reset err_flag", int'(err_flag), 0);
    check("R1 reset win_count", int'(win_count), 0);
    sw_unmute = 1'b1;
    @(negedge clk);
    check("R1 still muted before a window", int'(mute), 1);

    run_window(FL, 2, 1'b0, "R5 R2 quiet window releases");
    run_window(FL, 16, 1'b1, "R4 R9 R2 17 with closing error mutes");
    run_window(FL, 10, 1'b0, "R6 R10 mid count holds mute");
    run_window(FL, 3, 1'b0, "R5 count 3 releases");
    run_window(FL, 15, 1'b0, "R6 count 15 equal to limit holds");
    run_window(FL, 16, 1'b0, "R4 count 16 mutes");
    run_window(FL, 4, 1'b0, "R6 count 4 quarter boundary holds");
    lim_sel = 1'b1;
    run_window(FL, 1, 1'b0, "R5 low limit count 1 releases");
    run_window(FL, 8, 1'b0, "R4 low limit count 8 mutes");
    run_window(FL, 2, 1'b0, "R6 low limit count 2 holds");
    win_sel = 1'b1;
    run_window(FS, 40, 1'b0, "R3 R2 short window saturates");
    run_window(FS, 0, 1'b0, "R10 R5 empty window after saturation");

    // R7: software override
    @(negedge clk); sw_unmute = 1'b0;
    @(negedge clk);
    check("R7 sw_unmute=0 forces mute", int'(mute), 1);
    check("R7 count untouched", int'(win_count), 0);
    sw_unmute = 1'b1;
    @(negedge clk);
    check("R7 sw_unmute=1 restores decision", int'(mute), 0);

    // R8: alignment loss mid-window
    for (int i = 0; i < 30; i++) begin
      @(negedge clk); par_err = 1'b1;
      @(negedge clk); par_err = 1'b0;
    end
    for (int f = 0; f < 2; f++) begin
      @(negedge clk); frame_strb = 1'b1;
      @(negedge clk); frame_strb = 1'b0;
    end
    check("R8 mute before alignment loss", int'(mute), 0);
    align_ok = 1'b0;
    @(negedge clk);
    check("R8 alignment loss mutes", int'(mute), 1);
    align_ok = 1'b1;
    @(negedge clk);
    check("R8 decision left muted", int'(mute), 1);
    model_dec = 1'b1;
    run_window(FS, 1, 1'b0, "R8 R10 counters restarted after loss");

    repeat (3) @(negedge clk);
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total_checks, bad_checks);
    $finish;
  end

endmodule